// File: doc/BRIEF.md
# Zero-Test Branch Resolution Unit

This unit resolves conditional branches in a short in-order pipeline. It does not compare two registers. It looks at a single operand and decides whether the branch is taken from two facts only: whether the operand is all zeros, and the value of its top (sign) bit. No subtractor sits on the decision path.

Instructions enter a small pipeline model: a parameterised number of front stages, then a first execute stage (EX1), then a second execute stage (EX2). The taken/not-taken decision is formed combinationally while the branch sits in EX1 and is captured at the next edge. In EX2 the unit drives a registered redirect with the branch's precomputed target. In the same cycle it drives a flush that discards the instruction then in EX1, everything in the front stages, and the instruction presented at the input in that cycle.

A completion port (`doneValid`, `doneTag`) shows which instructions leave EX2. This makes the effect of a flush visible at the block's edge.

Top module: `zbr_unit`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `redirect`, `flush` and `doneValid` are low.
- R2: Condition code 2'b00 (zero test) makes a branch taken exactly when the operand equals zero.
- R3: Condition code 2'b01 (non-zero test) makes a branch taken exactly when the operand differs from zero.
- R4: Condition code 2'b10 (non-negative test) makes a branch taken exactly when the operand's most significant bit is 0, so a zero operand counts as taken.
- R5: Condition code 2'b11 (negative test) makes a branch taken exactly when the operand's most significant bit is 1.
- R6: An instruction presented with `inValid` high in cycle t reaches EX1 in cycle t+FRONT_STAGES+1 and EX2 in cycle t+FRONT_STAGES+2. If it is a taken branch (`inBranch` high), `redirect` is high in that EX2 cycle and `redirectPc` equals its `inTarget`.
- R7: `flush` is high in exactly the cycles where `redirect` is high. Each taken branch produces exactly one such cycle.
- R8: In a redirect cycle, the instruction in EX1, all front-stage instructions and the input presented in that cycle are discarded. They never appear on `doneValid` and cause no redirect. Every other valid instruction appears once on `doneValid`, with its own `inTag` on `doneTag`, in issue order, in cycle t+FRONT_STAGES+2.
- R9: A bubble (`inValid` low) or a non-branch instruction (`inBranch` low) never causes a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An instruction is presented this cycle |
| inBranch | input | 1 | The presented instruction is a conditional branch |
| inCond | input | 2 | Condition code: 00 zero, 01 non-zero, 10 non-negative, 11 negative |
| inOperand | input | OP_W | Register value tested against zero |
| inTarget | input | PC_W | Precomputed branch target |
| inTag | input | TAG_W | Identifier carried to the completion port |
| redirect | output | 1 | Taken branch in EX2: load `redirectPc` as the next PC |
| redirectPc | output | PC_W | Target of the branch being redirected |
| flush | output | 1 | Discard EX1, front stages and current input |
| doneValid | output | 1 | An instruction leaves EX2 this cycle |
| doneTag | output | TAG_W | Tag of the completing instruction |

## Verification
The embedded properties watch, on every cycle, the following:
- A bubble in EX1 never turns into a redirect.
- A redirect never lasts two cycles.
- The cycle after a flush has empty front stages and nothing completing.
- The captured target matches the EX1 target.
- The zero flag and the sign flag are never both set.

Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural queue model:
- Each condition code against zero, small, all-ones, largest-positive and most-negative operands.
- The exact latency from issue to redirect.
- Back-to-back taken branches, where the younger one must be silently discarded.
- Tag ordering on the completion port.

// File: rtl/zbr_pkg.sv
package zbr_pkg;

  typedef enum logic [1:0] {
    COND_EQZ = 2'b00,
    COND_NEZ = 2'b01,
    COND_GEZ = 2'b10,
    COND_LTZ = 2'b11
  } zbrCond_e;

  // datapath -> control: properties of the operand held in EX1
  typedef struct packed {
    logic ex1Zero;
    logic ex1Neg;
  } zbrFlags_t;

  // control -> datapath: strobes
  typedef struct packed {
    logic loadRedirect;  // EX1 branch is taken: capture its target
    logic flushAll;      // EX2 redirect active: scrub younger data
  } zbrStrobes_t;

endpackage

// File: rtl/zbr_zero_detect.sv
module zbr_zero_detect #(
  parameter int WIDTH = 64,
  parameter int CHUNK = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             isZero
);
  localparam int NCH  = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int PADW = NCH * CHUNK;

  logic [PADW-1:0] padded;
  logic [NCH-1:0]  chunkAny;

  assign padded = PADW'(value);

  // first level: one OR per chunk; second level: NOR across chunks
  for (genvar g = 0; g < NCH; g++) begin : gChunk
    assign chunkAny[g] = |padded[g*CHUNK +: CHUNK];
  end

  assign isZero = ~|chunkAny;

endmodule

// File: rtl/zbr_datapath.sv
module zbr_datapath
  import zbr_pkg::*;
#(
  parameter int OP_W         = 64,
  parameter int PC_W         = 32,
  parameter int TAG_W        = 8,
  parameter int FRONT_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   inOperand,
  input  logic [PC_W-1:0]   inTarget,
  input  logic [TAG_W-1:0]  inTag,
  input  zbrStrobes_t       strobes,
  output zbrFlags_t         flags,
  output logic [PC_W-1:0]   redirectPc,
  output logic [TAG_W-1:0]  doneTag
);
  localparam int F = FRONT_STAGES;

  logic [OP_W-1:0]  fOp  [F];
  logic [PC_W-1:0]  fTgt [F];
  logic [TAG_W-1:0] fTag [F];
  logic [OP_W-1:0]  ex1Op;
  logic [PC_W-1:0]  ex1Tgt;
  logic [TAG_W-1:0] ex1Tag;
  logic [PC_W-1:0]  redirPcQ;
  logic [TAG_W-1:0] ex2Tag;
  logic             ex1IsZero;

  zbr_zero_detect #(.WIDTH(OP_W), .CHUNK(8)) u_zeroDet (
    .value  (ex1Op),
    .isZero (ex1IsZero)
  );

  assign flags.ex1Zero = ex1IsZero;
  assign flags.ex1Neg  = ex1Op[OP_W-1];

  // front stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < F; i++) begin
        fOp[i]  <= '0;
        fTgt[i] <= '0;
        fTag[i] <= '0;
      end
    end else if (strobes.flushAll) begin
      for (int i = 0; i < F; i++) begin
        fOp[i]  <= '0;
        fTgt[i] <= '0;
        fTag[i] <= '0;
      end
    end else begin
      fOp[0]  <= inOperand;
      fTgt[0] <= inTarget;
      fTag[0] <= inTag;
      for (int i = 1; i < F; i++) begin
        fOp[i]  <= fOp[i-1];
        fTgt[i] <= fTgt[i-1];
        fTag[i] <= fTag[i-1];
      end
    end
  end

  // EX1 and EX2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ex1Op    <= '0;
      ex1Tgt   <= '0;
      ex1Tag   <= '0;
      redirPcQ <= '0;
      ex2Tag   <= '0;
    end else begin
      ex1Op  <= strobes.flushAll ? '0 : fOp[F-1];
      ex1Tgt <= strobes.flushAll ? '0 : fTgt[F-1];
      ex1Tag <= strobes.flushAll ? '0 : fTag[F-1];
      ex2Tag <= ex1Tag;
      if (strobes.loadRedirect) redirPcQ <= ex1Tgt;
    end
  end

  assign redirectPc = redirPcQ;
  assign doneTag    = ex2Tag;

  AST_PC_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRedirect |=> (redirectPc == $past(ex1Tgt))); // R6

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(flags.ex1Zero && flags.ex1Neg)); // R4

endmodule

// File: rtl/zbr_control.sv
module zbr_control
  import zbr_pkg::*;
#(
  parameter int FRONT_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inBranch,
  input  logic [1:0]  inCond,
  input  zbrFlags_t   flags,
  output zbrStrobes_t strobes,
  output logic        redirect,
  output logic        flush,
  output logic        doneValid
);
  localparam int F = FRONT_STAGES;

  logic [F-1:0] fV;
  logic [F-1:0] fBr;
  logic [1:0]   fCond [F];
  logic         ex1V, ex1Br;
  logic [1:0]   ex1Cond;
  logic         ex2V, ex2Taken;
  logic         killYoung;
  logic         condMet;
  logic         ex1Taken;

  assign killYoung = ex2V & ex2Taken;

  always_comb begin
    unique case (zbrCond_e'(ex1Cond))
      COND_EQZ: condMet =  flags.ex1Zero;
      COND_NEZ: condMet = ~flags.ex1Zero;
      COND_GEZ: condMet = ~flags.ex1Neg;
      COND_LTZ: condMet =  flags.ex1Neg;
      default:  condMet = 1'b0;
    endcase
  end

  assign ex1Taken = ex1V & ex1Br & condMet & ~killYoung;

  assign strobes.loadRedirect = ex1Taken;
  assign strobes.flushAll     = killYoung;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fV <= '0;
      fBr <= '0;
      for (int i = 0; i < F; i++) fCond[i] <= '0;
      ex1V     <= 1'b0;
      ex1Br    <= 1'b0;
      ex1Cond  <= '0;
      ex2V     <= 1'b0;
      ex2Taken <= 1'b0;
    end else begin
      fV[0]    <= inValid & ~killYoung;
      fBr[0]   <= inBranch;
      fCond[0] <= inCond;
      for (int i = 1; i < F; i++) begin
        fV[i]    <= fV[i-1] & ~killYoung;
        fBr[i]   <= fBr[i-1];
        fCond[i] <= fCond[i-1];
      end
      ex1V     <= fV[F-1] & ~killYoung;
      ex1Br    <= fBr[F-1];
      ex1Cond  <= fCond[F-1];
      ex2V     <= ex1V & ~killYoung;
      ex2Taken <= ex1Taken;
    end
  end

  assign redirect  = ex2V & ex2Taken;
  assign flush     = killYoung;
  assign doneValid = ex2V;

  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ex1V |=> !redirect); // R9

  AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ex1V && !ex1Br) |=> !redirect); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect); // R7

  AST_EX1_KILLED: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !doneValid); // R8

  AST_FRONT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> ((fV == '0) && !ex1V)); // R8

endmodule

// File: rtl/zbr_unit.sv
module zbr_unit
  import zbr_pkg::*;
#(
  parameter int OP_W         = 64,
  parameter int PC_W         = 32,
  parameter int TAG_W        = 8,
  parameter int FRONT_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inBranch,
  input  logic [1:0]       inCond,
  input  logic [OP_W-1:0]  inOperand,
  input  logic [PC_W-1:0]  inTarget,
  input  logic [TAG_W-1:0] inTag,
  output logic             redirect,
  output logic [PC_W-1:0]  redirectPc,
  output logic             flush,
  output logic             doneValid,
  output logic [TAG_W-1:0] doneTag
);
  zbrFlags_t   flags;
  zbrStrobes_t strobes;

  zbr_control #(.FRONT_STAGES(FRONT_STAGES)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inBranch  (inBranch),
    .inCond    (inCond),
    .flags     (flags),
    .strobes   (strobes),
    .redirect  (redirect),
    .flush     (flush),
    .doneValid (doneValid)
  );

  zbr_datapath #(
    .OP_W(OP_W), .PC_W(PC_W), .TAG_W(TAG_W), .FRONT_STAGES(FRONT_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .inOperand  (inOperand),
    .inTarget   (inTarget),
    .inTag      (inTag),
    .strobes    (strobes),
    .flags      (flags),
    .redirectPc (redirectPc),
    .doneTag    (doneTag)
  );

  AST_REDIRECT_HAS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> doneValid); // R6

endmodule

// File: tb/zbr_unit_bench.sv
module zbr_unit_bench;
  localparam int OP_W = 64;
  localparam int PC_W = 32;
  localparam int TAG_W = 8;
  localparam int F = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inBranch = 1'b0;
  logic [1:0] inCond = '0;
  logic [OP_W-1:0] inOperand = '0;
  logic [PC_W-1:0] inTarget = '0;
  logic [TAG_W-1:0] inTag = '0;
  logic redirect, flush, doneValid;
  logic [PC_W-1:0] redirectPc;
  logic [TAG_W-1:0] doneTag;

  int checks = 0;
  int fails = 0;
  bit running = 0;
  int tagCnt = 0;

  always #2 clk = ~clk;

  zbr_unit #(.OP_W(OP_W), .PC_W(PC_W), .TAG_W(TAG_W), .FRONT_STAGES(F)) u_zbr_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBranch(inBranch), .inCond(inCond),
    .inOperand(inOperand), .inTarget(inTarget), .inTag(inTag),
    .redirect(redirect), .redirectPc(redirectPc), .flush(flush),
    .doneValid(doneValid), .doneTag(doneTag)
  );

  typedef struct {
    bit br;
    bit [1:0] cond;
    logic [OP_W-1:0] op;
    logic [PC_W-1:0] tgt;
    logic [TAG_W-1:0] tag;
    int age;
  } ent_t;

  ent_t q[$];
  ent_t nq[$];
  ent_t e;
  bit redirNow;

  function automatic bit isTaken(ent_t x);
    if (!x.br) return 0;
    case (x.cond)
      2'd0: return x.op == 0;
      2'd1: return x.op != 0;
      2'd2: return !x.op[OP_W-1];
      default: return x.op[OP_W-1];
    endcase
  endfunction

  function automatic string condReq(bit [1:0] c);
    case (c)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model: list of in-flight instructions with their age
  always @(posedge clk) begin
    if (!rstN) q.delete();
    else begin
      redirNow = 0;
      foreach (q[i]) if (q[i].age == F + 1 && isTaken(q[i])) redirNow = 1;
      if (redirNow) q.delete();  // R8: everything younger is dropped
      else begin
        nq.delete();
        foreach (q[i]) if (q[i].age <= F) begin
          e = q[i];
          e.age++;
          nq.push_back(e);
        end
        if (inValid) begin
          e.br = inBranch; e.cond = inCond; e.op = inOperand;
          e.tgt = inTarget; e.tag = inTag; e.age = 0;
          nq.push_back(e);
        end
        q = nq;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && running) begin
      bit expDone, expRedir, expBr;
      bit [1:0] expCond;
      logic [TAG_W-1:0] expTag;
      logic [PC_W-1:0] expPc;
      expDone = 0; expRedir = 0; expBr = 0; expCond = 0; expTag = 0; expPc = 0;
      foreach (q[i]) if (q[i].age == F + 1) begin
        expDone = 1; expTag = q[i].tag; expRedir = isTaken(q[i]);
        expBr = q[i].br; expCond = q[i].cond; expPc = q[i].tgt;
      end
      chk("R8", "doneValid", 64'(doneValid), 64'(expDone));
      if (expDone) chk("R8", "doneTag", 64'(doneTag), 64'(expTag));
      chk(expBr ? condReq(expCond) : "R9", "redirect", 64'(redirect), 64'(expRedir));
      chk("R7", "flush", 64'(flush), 64'(expRedir));
      if (expRedir) chk("R6", "redirectPc", 64'(redirectPc), 64'(expPc));
    end
  end

  task automatic issue(bit br, bit [1:0] c, logic [OP_W-1:0] op);
    @(negedge clk);
    tagCnt++;
    inValid = 1; inBranch = br; inCond = c; inOperand = op;
    inTarget = PC_W'(32'h1000_0000 + tagCnt * 4); inTag = TAG_W'(tagCnt);
  endtask

  task automatic bubble(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 0; inBranch = $urandom % 2; inOperand = '0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [OP_W-1:0] pats [5];
    pats[0] = '0;
    pats[1] = 64'd1;
    pats[2] = '1;
    pats[3] = {1'b0, {(OP_W-1){1'b1}}};
    pats[4] = {1'b1, {(OP_W-1){1'b0}}};

    repeat (3) @(negedge clk);
    chk("R1", "redirect in reset", 64'(redirect), 0);
    chk("R1", "flush in reset", 64'(flush), 0);
    chk("R1", "doneValid in reset", 64'(doneValid), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1", "redirect after reset", 64'(redirect), 0);
    chk("R1", "doneValid after reset", 64'(doneValid), 0);
    running = 1;

    // R9: non-branches and bubbles
    for (int i = 0; i < 4; i++) issue(0, 2'(i), '0);
    bubble(5);

    // R2..R5: each condition against each pattern, isolated
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 5; p++) begin
        issue(1, 2'(c), pats[p]);
        bubble(5);
      end

    // R8: back-to-back taken branches; younger ones must vanish
    issue(1, 2'd0, '0);
    issue(1, 2'd0, '0);
    issue(1, 2'd1, 64'd7);
    issue(0, 2'd0, '0);
    issue(0, 2'd0, '0);
    bubble(6);

    // R6: not-taken branch followed by taken one
    issue(1, 2'd3, 64'd5);
    issue(1, 2'd2, 64'd5);
    issue(0, 2'd0, '0);
    bubble(6);

    // mixed random stream
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 4 == 0) bubble(1);
      else begin
        logic [OP_W-1:0] op;
        case ($urandom % 4)
          0: op = '0;
          1: op = pats[$urandom % 5];
          default: op = {$urandom, $urandom};
        endcase
        issue(($urandom % 3) != 0, 2'($urandom % 4), op);
      end
    end
    bubble(8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule